// File: doc/BRIEF.md
# Serial Receiver with Error-Tagged Receive Buffer

This block recovers characters from an asynchronous serial line. An external divider supplies a tick at sixteen times the bit rate. The block waits for the line to fall from its high idle level. It confirms the start bit at its half-bit point, then samples every data, parity and stop bit at its midpoint. The data width, the parity mode and the stop length are static configuration inputs.

Each finished character is stored together with three status bits: a parity mismatch, a low stop sample, and a break, meaning every sample of the frame was low. After reset the store holds a single character. Setting the buffered-mode input turns it into a first-in first-out queue of sixteen entries. The host sees the oldest entry on the read outputs. It removes that entry with a one-cycle pop strobe and watches the available, empty and full flags. A separate overrun flag reports characters that were lost because the store was full.

Top module: `serial_rx_tagbuf`

## Requirements
- R1: After reset the block is in single-character mode: `data_avail`=0, `buf_empty`=1, `buf_full`=0, `overrun`=0 and `rd_data`=0.
- R2: Bits arrive least significant first after a low start bit. `cfg_data_bits` 0,1,2,3 selects 5,6,7,8 data bits. The character appears right-aligned on `rd_data` with its unused upper bits zero.
- R3: When `cfg_par_en`=1 a parity bit follows the data bits. `cfg_par_odd`=0 expects an even count of ones over data and parity, and 1 expects an odd count. A mismatch sets `rd_perr` for that entry.
- R4: `cfg_stop` 0 selects one stop bit, 1 selects one and a half, and 2 (or 3) selects two. With one stop bit the line is checked at mid-stop. With the longer settings it is also checked in the middle of the extra stop time. Any low check sets `rd_ferr`.
- R5: A frame whose every sample is low is stored once with `rd_brk`=1, `rd_ferr`=1 and data 0. No further frame starts until the line has been seen high.
- R6: A low on the line that is high again at the half-bit check of the start bit is discarded and stores nothing.
- R7: In single-character mode the store holds one entry, and `buf_full` rises as soon as it is occupied.
- R8: In buffered mode (`cfg_buffered`=1) the store holds 16 entries, returned in arrival order, and `buf_full` rises at 16.
- R9: A character that completes while the store is full is dropped, the stored entries are kept, and `overrun` is set. The next accepted pop clears `overrun`.
- R10: A pop while the store is empty has no effect.
- R11: Changing `cfg_buffered` empties the store and clears `overrun`.
- R12: Frames with 8 data bits, no parity and one stop bit are received correctly for bit widths from 0.97 to 1.047 of the nominal bit time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial line, high when idle |
| cfg_buffered | input | 1 | 0 = one-character store, 1 = 16-entry queue |
| cfg_data_bits | input | 2 | Data width minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop | input | 2 | Stop length: 0 = 1, 1 = 1.5, 2 or 3 = 2 bits |
| pop | input | 1 | Remove the oldest entry |
| rd_data | output | 8 | Data of the oldest entry |
| rd_perr | output | 1 | Parity error flag of the oldest entry |
| rd_ferr | output | 1 | Framing error flag of the oldest entry |
| rd_brk | output | 1 | Break flag of the oldest entry |
| data_avail | output | 1 | At least one entry is stored |
| buf_empty | output | 1 | No entry is stored |
| buf_full | output | 1 | Store is at capacity for the current mode |
| overrun | output | 1 | A character was lost since the last pop |

## Verification
A sampling counter that is off by a tick stays hidden on nominal frames. It shows up on the read outputs only when bits are stretched or shrunk, so the bench sends frames at both ends of the tolerance band. A wrong bit index or a wrong final state shifts or truncates the stored byte, or misplaces a flag, on the very next entry. A wrong occupancy count shows as a full flag at the wrong depth, as an early overrun, or as entries popped out of order within one queue fill. Each of these shows within a frame or two of the faulty state.

// File: rtl/serial_rx_tagbuf.sv
module serial_rx_tagbuf #(
  parameter int DEPTH = 16,
  parameter int OVS   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       rxd,
  input  logic       cfg_buffered,
  input  logic [1:0] cfg_data_bits,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic [1:0] cfg_stop,
  input  logic       pop,
  output logic [7:0] rd_data,
  output logic       rd_perr,
  output logic       rd_ferr,
  output logic       rd_brk,
  output logic       data_avail,
  output logic       buf_empty,
  output logic       buf_full,
  output logic       overrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] HALF  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] FULLC = CW'(OVS - 1);
  localparam logic [CW-1:0] THREEQ = CW'(OVS*3/4 - 1);
  localparam logic [AW:0] CAPB = (AW+1)'(DEPTH);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    bidx;
  logic [7:0]    sh;
  logic          par_acc, par_bad, all_low, ferr_acc, stop2nd, line_hi;
  logic          done;
  logic [10:0]   done_word;

  logic          ferr_n, low_n, last_data, stop_hit;
  logic [CW-1:0] stop_lim;
  logic [7:0]    rx_byte;

  assign ferr_n    = ferr_acc | ~rxd;
  assign low_n     = all_low & ~rxd;
  assign last_data = (bidx == {1'b1, cfg_data_bits});
  assign stop_lim  = (stop2nd && cfg_stop == 2'd1) ? THREEQ : FULLC;
  assign stop_hit  = (cnt == stop_lim);
  assign rx_byte   = sh >> (2'd3 - cfg_data_bits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      bidx      <= '0;
      sh        <= '0;
      par_acc   <= 1'b0;
      par_bad   <= 1'b0;
      all_low   <= 1'b0;
      ferr_acc  <= 1'b0;
      stop2nd   <= 1'b0;
      line_hi   <= 1'b0;
      done      <= 1'b0;
      done_word <= '0;
    end else begin
      done <= 1'b0;
      if (baud_tick) begin
        case (st)
          S_IDLE: begin
            line_hi <= rxd;
            if (!rxd && line_hi) begin
              st  <= S_START;
              cnt <= '0;
            end
          end
          S_START: begin
            if (cnt == HALF) begin
              cnt <= '0;
              if (rxd) begin
                st      <= S_IDLE;
                line_hi <= 1'b1;
              end else begin
                st      <= S_DATA;
                bidx    <= '0;
                all_low <= 1'b1;
                par_acc <= 1'b0;
                par_bad <= 1'b0;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            if (cnt == FULLC) begin
              cnt     <= '0;
              sh      <= {rxd, sh[7:1]};
              par_acc <= par_acc ^ rxd;
              all_low <= low_n;
              if (last_data) begin
                st       <= cfg_par_en ? S_PAR : S_STOP;
                stop2nd  <= 1'b0;
                ferr_acc <= 1'b0;
              end else begin
                bidx <= bidx + 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_PAR: begin
            if (cnt == FULLC) begin
              cnt      <= '0;
              par_bad  <= ((par_acc ^ rxd) != cfg_par_odd);
              all_low  <= low_n;
              st       <= S_STOP;
              stop2nd  <= 1'b0;
              ferr_acc <= 1'b0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_STOP: begin
            if (stop_hit) begin
              cnt <= '0;
              if (!stop2nd && cfg_stop != 2'd0) begin
                stop2nd  <= 1'b1;
                ferr_acc <= ferr_n;
                all_low  <= low_n;
              end else begin
                st        <= S_IDLE;
                done      <= 1'b1;
                done_word <= {low_n, ferr_n, par_bad, rx_byte};
                line_hi   <= rxd;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  logic [10:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt_q;
  logic          mode_q;
  logic          push, popok, flush;

  assign flush    = (cfg_buffered != mode_q);
  assign buf_full = (cnt_q == (mode_q ? CAPB : (AW+1)'(1)));
  assign push     = done && !buf_full && !flush;
  assign popok    = pop && (cnt_q != '0) && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      wp      <= '0;
      rp      <= '0;
      cnt_q   <= '0;
      overrun <= 1'b0;
    end else begin
      mode_q <= cfg_buffered;
      if (flush) begin
        wp      <= '0;
        rp      <= '0;
        cnt_q   <= '0;
        overrun <= 1'b0;
      end else begin
        if (push)  wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
        if (popok) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
        cnt_q <= cnt_q + (AW+1)'(push) - (AW+1)'(popok);
        if (done && buf_full) overrun <= 1'b1;
        else if (popok)       overrun <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= done_word;
  end

  assign data_avail = (cnt_q != '0);
  assign buf_empty  = ~data_avail;
  assign {rd_brk, rd_ferr, rd_perr, rd_data} = data_avail ? mem[rp] : 11'd0;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CAPB) else $error("queue count above depth"); // R8
  AST_SINGLE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> cnt_q <= (AW+1)'(1)) else $error("single mode holds more than one"); // R7
  AST_OVR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && buf_full && !pop && !flush) |=> (cnt_q == $past(cnt_q)) && overrun) else $error("overrun lost contents"); // R9
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && buf_empty && !done) |=> buf_empty) else $error("pop on empty changed store"); // R10
  AST_BRK_FERR: assert property (@(posedge clk) disable iff (!rst_n)
    (data_avail && rd_brk) |-> rd_ferr) else $error("break without framing flag"); // R5
  AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_buffered != mode_q) |=> buf_empty && !overrun) else $error("mode change kept entries"); // R11
endmodule

// File: tb/serial_rx_tagbuf_tb.sv
module serial_rx_tagbuf_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic cfg_buffered = 1'b0;
  logic [1:0] cfg_data_bits = 2'd3;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic [1:0] cfg_stop = 2'd0;
  logic pop = 1'b0;
  logic [7:0] rd_data;
  logic rd_perr, rd_ferr, rd_brk, data_avail, buf_empty, buf_full, overrun;
  logic [1:0] tdiv = 2'd0;
  logic baud_tick;
  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign baud_tick = (tdiv == 2'd3);

  serial_rx_tagbuf u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
    .cfg_buffered(cfg_buffered), .cfg_data_bits(cfg_data_bits),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_stop(cfg_stop),
    .pop(pop), .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr),
    .rd_brk(rd_brk), .data_avail(data_avail), .buf_empty(buf_empty),
    .buf_full(buf_full), .overrun(overrun)
  );

  // [15:14] width code, [13] parity on, [12] odd, [11:10] stop, [9] flip parity, [8] low stop, [7:0] data
  localparam logic [15:0] VEC [8] = '{
    {2'd3, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 8'hA5},
    {2'd0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 8'h1F},
    {2'd1, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0, 8'h2C},
    {2'd2, 1'b1, 1'b0, 2'd2, 1'b1, 1'b0, 8'h5A},
    {2'd3, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 8'hC3},
    {2'd3, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 8'h81},
    {2'd0, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 8'hFF},
    {2'd2, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 8'h00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit flip, input bit s1, input bit s2, input int bc);
    int nb;
    logic p;
    nb = 5 + int'(cfg_data_bits);
    p = cfg_par_odd;
    hold(1'b0, bc);
    for (int i = 0; i < nb; i++) begin
      hold(d[i], bc);
      p = p ^ d[i];
    end
    if (cfg_par_en) hold(p ^ flip, bc);
    hold(s1, bc);
    if (cfg_stop == 2'd1) hold(s2, bc / 2);
    else if (cfg_stop != 2'd0) hold(s2, bc);
    hold(1'b1, 2 * bc);
  endtask

  task automatic do_pop;
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    // R1 reset state
    check("R1 data_avail", data_avail, 0);
    check("R1 buf_empty", buf_empty, 1);
    check("R1 buf_full", buf_full, 0);
    check("R1 overrun", overrun, 0);
    check("R1 rd_data", rd_data, 0);

    // R7 single mode, R9 overrun, R10 empty pop
    send(8'h11, 0, 1, 1, 64);
    check("R7 avail", data_avail, 1);
    check("R7 full after one", buf_full, 1);
    send(8'h22, 0, 1, 1, 64);
    check("R9 overrun set", overrun, 1);
    check("R9 kept first", rd_data, 8'h11);
    do_pop();
    check("R9 overrun cleared", overrun, 0);
    check("R9 empty after pop", buf_empty, 1);
    do_pop();
    check("R10 empty pop", buf_empty, 1);
    check("R10 not full", buf_full, 0);

    // R6 glitch
    hold(1'b0, 12);
    hold(1'b1, 256);
    check("R6 glitch stores nothing", data_avail, 0);

    // R5 break
    hold(1'b0, 12 * 64);
    hold(1'b1, 128);
    check("R5 break stored", data_avail, 1);
    check("R5 brk flag", rd_brk, 1);
    check("R5 ferr flag", rd_ferr, 1);
    check("R5 data zero", rd_data, 0);
    do_pop();
    check("R5 single entry", buf_empty, 1);

    // table in buffered mode: R2 R3 R4
    cfg_buffered = 1'b1;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      logic [7:0] mask;
      cfg_data_bits = VEC[k][15:14];
      cfg_par_en    = VEC[k][13];
      cfg_par_odd   = VEC[k][12];
      cfg_stop      = VEC[k][11:10];
      mask = 8'hFF >> (3 - int'(VEC[k][15:14]));
      send(VEC[k][7:0], VEC[k][9], ~VEC[k][8], 1'b1, 64);
      check("R2 table data", rd_data, VEC[k][7:0] & mask);
      check("R3 table parity flag", rd_perr, VEC[k][9] & VEC[k][13]);
      check("R4 table framing flag", rd_ferr, VEC[k][8]);
      do_pop();
    end

    // R4 extra stop time low
    cfg_data_bits = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
    cfg_stop = 2'd2;
    send(8'h3C, 0, 1, 0, 64);
    check("R4 two-stop second low", rd_ferr, 1);
    check("R4 two-stop not break", rd_brk, 0);
    do_pop();
    cfg_stop = 2'd1;
    send(8'h3D, 0, 1, 0, 64);
    check("R4 one-and-half second low", rd_ferr, 1);
    do_pop();
    cfg_stop = 2'd0;

    // R12 tolerance
    send(8'h96, 0, 1, 1, 62);
    check("R12 short bits data", rd_data, 8'h96);
    check("R12 short bits ferr", rd_ferr, 0);
    do_pop();
    send(8'h69, 0, 1, 1, 67);
    check("R12 long bits data", rd_data, 8'h69);
    check("R12 long bits ferr", rd_ferr, 0);
    do_pop();

    // R8 depth and order, R9 in buffered mode
    for (int i = 0; i < 16; i++) begin
      send(8'(i * 7 + 3), 0, 1, 1, 64);
      if (i == 14) check("R8 not full at 15", buf_full, 0);
    end
    check("R8 full at 16", buf_full, 1);
    send(8'hEE, 0, 1, 1, 64);
    check("R9 overrun buffered", overrun, 1);
    for (int i = 0; i < 16; i++) begin
      check("R8 order", rd_data, 8'(i * 7 + 3));
      do_pop();
    end
    check("R8 drained", buf_empty, 1);

    // R11 flush on mode change
    send(8'h44, 0, 1, 1, 64);
    send(8'h55, 0, 1, 1, 64);
    check("R11 entries before switch", data_avail, 1);
    cfg_buffered = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 flushed", buf_empty, 1);
    check("R11 overrun clear", overrun, 0);

    finish_run();
  end
endmodule